// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt and DMA Request Generator

This block sits beside the receive and transmit FIFOs of a serial controller and turns their fill levels into service requests. Each FIFO has a programmable threshold. The receive side asks for service once enough bytes have arrived. The transmit side asks for service once enough room has opened up. Each side keeps a sticky status flag and drives a DMA request line. The status flags are masked by an enable register, then ORed onto a single interrupt output.

Software sets the thresholds through a small register port. It sets and clears enable bits through two separate write-one registers. It acknowledges a flag by writing a one to that flag's bit in the status register. A flag whose condition still holds is caught again at once, so the request never goes away while service is still due. The FIFO levels are already in the register clock domain when they reach this block.

Top module: `fifo_level_events`

## Requirements
- R1: The receive condition is true when `rxLevel` is greater than the receive threshold value N, meaning N+1 or more bytes are held. N is written to address 0 bits [TH_W-1:0], where TH_W = clog2(DEPTH). So N = 0 fires on the first byte.
- R2: The transmit condition is true when DEPTH minus `txLevel` is greater than the transmit threshold M, meaning M+1 or more free bytes. M is written to address 0 bits [16+TH_W-1:16]. Address 0 reads back both fields at the same positions.
- R3: A status flag sets on the first clock edge at which its condition is true. The receive flag is bit 0 and the transmit flag is bit 1 of address 3.
- R4: A status flag clears only when a one is written to its bit at address 3. Writing a zero has no effect. A clearing write made while the condition still holds leaves the flag set.
- R5: Writing ones to address 1 sets enable bits, and writing ones to address 2 clears them. Zero bits in either write leave the enable unchanged. Reads of address 1 or 2 return the enable mask in bits [1:0].
- R6: `irqOut` is high exactly when some status flag and its enable bit are both set. It changes in the same cycle as the flags and the mask.
- R7: `rxDmaReq` and `txDmaReq` are registered copies of the receive and transmit conditions. Each is gated by its DMA enable bit at address 4: bit 0 for receive, bit 1 for transmit. The interrupt enables and the status flags have no effect on them.
- R8: While `rstN` is low, the thresholds, enables, DMA enables, flags, `irqOut` and both DMA requests are all zero.
- R9: Address 3 bits [31:16] read back the DEPTH parameter. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLevel | input | LVL_W | Bytes held in the receive FIFO (0..DEPTH) |
| txLevel | input | LVL_W | Bytes held in the transmit FIFO (0..DEPTH) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for both write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr`, combinational |
| irqOut | output | 1 | Combined masked interrupt |
| rxDmaReq | output | 1 | Receive DMA request level |
| txDmaReq | output | 1 | Transmit DMA request level |

## Verification
The status flags and both DMA requests appear one clock edge after the levels or writes that cause them. `irqOut` follows the flags and the mask with no further delay, and `regRdData` follows `regAddr` within the same cycle. The bench applies every stimulus just after a falling edge. Its model steps once at each rising edge, using the inputs held across that edge. All outputs are compared at the next falling edge, so each result is checked in the first cycle it is due.

// File: rtl/fle_pkg.sv
package fle_pkg;
  localparam int SRC_N = 2;
  localparam int HI_LSB = 16;
  localparam logic [2:0] A_THRESH = 3'd0;
  localparam logic [2:0] A_EN_SET = 3'd1;
  localparam logic [2:0] A_EN_CLR = 3'd2;
  localparam logic [2:0] A_STATUS = 3'd3;
  localparam logic [2:0] A_DMA_EN = 3'd4;

  typedef struct packed {
    logic thrWr;
    logic enSet;
    logic enClr;
    logic stsClr;
    logic dmaWr;
  } regStrb_t;
endpackage

// File: rtl/fle_ctrl.sv
module fle_ctrl
  import fle_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int TH_W  = $clog2(DEPTH)
) (
  input  logic                         regWrEn,
  input  logic [2:0]                   regAddr,
  input  logic [SRC_N-1:0][TH_W-1:0]   thrVec,
  input  logic [SRC_N-1:0]             enVec,
  input  logic [SRC_N-1:0]             flagVec,
  input  logic [SRC_N-1:0]             dmaEnVec,
  output regStrb_t                     strb,
  output logic [31:0]                  regRdData
);
  localparam logic [15:0] DEPTH_FIELD = 16'(DEPTH);

  always_comb begin
    strb = '0;
    if (regWrEn) begin
      unique case (regAddr)
        A_THRESH: strb.thrWr  = 1'b1;
        A_EN_SET: strb.enSet  = 1'b1;
        A_EN_CLR: strb.enClr  = 1'b1;
        A_STATUS: strb.stsClr = 1'b1;
        A_DMA_EN: strb.dmaWr  = 1'b1;
        default:  strb = '0;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      A_THRESH: begin
        regRdData[TH_W-1:0]        = thrVec[0];
        regRdData[HI_LSB +: TH_W]  = thrVec[1];
      end
      A_EN_SET, A_EN_CLR: regRdData[SRC_N-1:0] = enVec;
      A_STATUS: begin
        regRdData[SRC_N-1:0]       = flagVec;
        regRdData[31:HI_LSB]       = DEPTH_FIELD;
      end
      A_DMA_EN: regRdData[SRC_N-1:0] = dmaEnVec;
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/fle_datapath.sv
module fle_datapath
  import fle_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int TH_W  = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  regStrb_t                    strb,
  input  logic [31:0]                 wrData,
  input  logic [LVL_W-1:0]            rxLevel,
  input  logic [LVL_W-1:0]            txLevel,
  output logic [SRC_N-1:0][TH_W-1:0]  thrVec,
  output logic [SRC_N-1:0]            enVec,
  output logic [SRC_N-1:0]            flagVec,
  output logic [SRC_N-1:0]            dmaEnVec,
  output logic [SRC_N-1:0]            dmaReqVec,
  output logic                        irqOut
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

  // Measured quantity per source: bytes held (rx) or bytes free (tx).
  logic [SRC_N-1:0][LVL_W-1:0] measure;
  logic [SRC_N-1:0]            cond;

  assign measure[0] = rxLevel;
  assign measure[1] = DEPTH_L - txLevel;

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    assign cond[g] = measure[g] > LVL_W'(thrVec[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        thrVec[g]    <= '0;
        enVec[g]     <= 1'b0;
        flagVec[g]   <= 1'b0;
        dmaEnVec[g]  <= 1'b0;
        dmaReqVec[g] <= 1'b0;
      end else begin
        if (strb.thrWr)
          thrVec[g] <= wrData[g*HI_LSB +: TH_W];
        if (strb.enSet && wrData[g])
          enVec[g] <= 1'b1;
        else if (strb.enClr && wrData[g])
          enVec[g] <= 1'b0;
        if (strb.dmaWr)
          dmaEnVec[g] <= wrData[g];
        // A set condition wins over a same-cycle acknowledge.
        flagVec[g]   <= (flagVec[g] & ~(strb.stsClr & wrData[g])) | cond[g];
        dmaReqVec[g] <= dmaEnVec[g] & cond[g];
      end
    end
  end

  assign irqOut = |(flagVec & enVec);
endmodule

// File: rtl/fifo_level_events.sv
module fifo_level_events
  import fle_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int TH_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  output logic             irqOut,
  output logic             rxDmaReq,
  output logic             txDmaReq
);
  regStrb_t                   strb;
  logic [SRC_N-1:0][TH_W-1:0] thrVec;
  logic [SRC_N-1:0]           enVec;
  logic [SRC_N-1:0]           flagVec;
  logic [SRC_N-1:0]           dmaEnVec;
  logic [SRC_N-1:0]           dmaReqVec;

  fle_ctrl #(.DEPTH(DEPTH), .TH_W(TH_W)) u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .thrVec    (thrVec),
    .enVec     (enVec),
    .flagVec   (flagVec),
    .dmaEnVec  (dmaEnVec),
    .strb      (strb),
    .regRdData (regRdData)
  );

  fle_datapath #(.DEPTH(DEPTH), .LVL_W(LVL_W), .TH_W(TH_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (regWrData),
    .rxLevel   (rxLevel),
    .txLevel   (txLevel),
    .thrVec    (thrVec),
    .enVec     (enVec),
    .flagVec   (flagVec),
    .dmaEnVec  (dmaEnVec),
    .dmaReqVec (dmaReqVec),
    .irqOut    (irqOut)
  );

  assign rxDmaReq = dmaReqVec[0];
  assign txDmaReq = dmaReqVec[1];
endmodule

// File: rtl/fle_chk.sv
module fle_chk #(
  parameter  int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int TH_W  = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic [LVL_W-1:0] rxLevel,
  input logic             regWrEn,
  input logic [2:0]       regAddr,
  input logic [31:0]      regWrData,
  input logic             irqOut,
  input logic             rxDmaReq,
  input logic [1:0]       flagQ,
  input logic [1:0]       enQ,
  input logic [TH_W-1:0]  rxThr,
  input logic [1:0]       dmaEn
);
  logic rxAck;
  logic rxHit;
  assign rxAck = regWrEn && (regAddr == 3'd3) && regWrData[0];
  assign rxHit = rxLevel > LVL_W'(rxThr);

  p_cond_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxHit |=> flagQ[0]);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ[0] && !rxAck) |=> flagQ[0]);

  p_en_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd2 && regWrData[0]) |=> !enQ[0]);

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == 2'b00) |-> !irqOut);

  p_dma_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rxHit |=> !rxDmaReq);

  p_dma_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dmaEn[0] |=> !rxDmaReq);
endmodule

bind fifo_level_events fle_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rxLevel   (rxLevel),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .irqOut    (irqOut),
  .rxDmaReq  (rxDmaReq),
  .flagQ     (flagVec),
  .enQ       (enVec),
  .rxThr     (thrVec[0]),
  .dmaEn     (dmaEnVec)
);

// File: tb/fifo_level_events_bench.sv
module fifo_level_events_bench;
  localparam int DEPTH = 32;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int TH_W  = $clog2(DEPTH);
  localparam int TH_MASK = (1 << TH_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [LVL_W-1:0] rxLevel = '0;
  logic [LVL_W-1:0] txLevel = '0;
  logic             regWrEn = 1'b0;
  logic [2:0]       regAddr = 3'd3;
  logic [31:0]      regWrData = '0;
  logic [31:0]      regRdData;
  logic             irqOut, rxDmaReq, txDmaReq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference model state
  int       mRxTh, mTxTh;
  bit [1:0] mEn, mFlag, mDma, mReq;

  always #5 clk = ~clk;

  fifo_level_events #(.DEPTH(DEPTH)) u_fifo_level_events (
    .clk(clk), .rstN(rstN), .rxLevel(rxLevel), .txLevel(txLevel),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut),
    .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model steps on each rising edge with the inputs held across it.
  always @(posedge clk) begin
    if (!rstN) begin
      mRxTh = 0; mTxTh = 0; mEn = 0; mFlag = 0; mDma = 0; mReq = 0;
    end else begin
      bit [1:0] c, nFlag;
      c[0] = int'(rxLevel) > mRxTh;
      c[1] = (DEPTH - int'(txLevel)) > mTxTh;
      nFlag = mFlag;
      if (regWrEn && regAddr == 3'd3) nFlag = nFlag & ~regWrData[1:0];
      nFlag = nFlag | c;
      mReq = mDma & c;
      mFlag = nFlag;
      if (regWrEn) begin
        case (regAddr)
          3'd0: begin
            mRxTh = int'(regWrData[15:0]) & TH_MASK;
            mTxTh = int'(regWrData[31:16]) & TH_MASK;
          end
          3'd1: mEn = mEn | regWrData[1:0];
          3'd2: mEn = mEn & ~regWrData[1:0];
          3'd4: mDma = regWrData[1:0];
          default: ;
        endcase
      end
    end
  end

  function automatic longint expRd(logic [2:0] a);
    case (a)
      3'd0: return longint'(mRxTh) | (longint'(mTxTh) << 16);
      3'd1, 3'd2: return longint'(mEn);
      3'd3: return longint'(mFlag) | (longint'(DEPTH) << 16);
      3'd4: return longint'(mDma);
      default: return 0;
    endcase
  endfunction

  function automatic string rdTag(logic [2:0] a);
    case (a)
      3'd0: return "R1 threshold readback";
      3'd1, 3'd2: return "R5 enable readback";
      3'd3: return "R4 status readback";
      3'd4: return "R7 dma enable readback";
      default: return "R9 unmapped readback";
    endcase
  endfunction

  // Every-cycle comparison at the falling edge.
  always @(negedge clk) begin
    if (!finished) begin
      chk("R6 irqOut", irqOut, |(mFlag & mEn));
      chk("R7 rxDmaReq", rxDmaReq, mReq[0]);
      chk("R7 txDmaReq", txDmaReq, mReq[1]);
      chk(rdTag(regAddr), regRdData, expRd(regAddr));
    end
  end

  task automatic nxt();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    nxt();
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    nxt();
    regWrEn = 1'b0; regAddr = 3'd3;
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) nxt();
    @(negedge clk);
    chk("R8 irqOut in reset", irqOut, 0);
    chk("R8 rxDmaReq in reset", rxDmaReq, 0);
    chk("R8 txDmaReq in reset", txDmaReq, 0);
    #1 regAddr = 3'd0;
    @(negedge clk);
    chk("R8 thresholds in reset", regRdData, 0);
    #1 rstN = 1'b1; regAddr = 3'd3;

    // R9: depth field
    @(negedge clk);
    chk("R9 depth field", regRdData[31:16], DEPTH);

    wr(3'd4, 32'h3);
    // R1: threshold 0 fires on first byte
    nxt(); rxLevel = 1;
    @(negedge clk);
    chk("R1 rx flag on one byte", regRdData[0], 1);

    // R4: acknowledge while condition holds keeps flag set
    wr(3'd3, 32'h1);
    chk("R4 ack under condition", regRdData[0], 1);
    nxt(); rxLevel = 0;
    wr(3'd3, 32'h1);
    chk("R4 ack clears flag", regRdData[0], 0);
    wr(3'd3, 32'h0);

    // R5: set then clear enables
    wr(3'd1, 32'h3);
    wr(3'd2, 32'h1);
    regAddr = 3'd1;
    @(negedge clk);
    chk("R5 enable mask", regRdData[1:0], 2'b10);

    // R2: tx threshold 10 needs 11 free bytes
    wr(3'd0, (32'd10 << 16) | 32'd5);
    nxt(); txLevel = LVL_W'(22);
    repeat (2) nxt();
    wr(3'd3, 32'h2);
    @(negedge clk);
    chk("R2 ten free bytes below threshold", regRdData[1], 0);
    chk("R2 tx dma low", txDmaReq, 0);
    #1 txLevel = LVL_W'(21);
    @(negedge clk);
    chk("R3 tx flag after one edge", regRdData[1], 1);
    chk("R2 tx dma high", txDmaReq, 1);

    // Mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      nxt();
      rxLevel = LVL_W'($urandom_range(0, DEPTH));
      txLevel = LVL_W'($urandom_range(0, DEPTH));
      regWrEn = ($urandom_range(0, 3) == 0);
      regAddr = 3'($urandom_range(0, 6));
      regWrData = $urandom;
      if (regAddr == 3'd0) regWrData = regWrData & 32'h001F_001F;
    end
    nxt();
    regWrEn = 1'b0;
    repeat (2) nxt();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule